// File: doc/BRIEF.md
# Floating-Point Rounding and Exception-Flag Control Word

This block keeps the architectural control word of a floating-point unit. The word holds a 3-bit dynamic rounding mode and five sticky exception flags. Software reaches it through one access port. An access either reads the whole word, the rounding-mode field alone, or the flag field alone. Each access may also swap the field. The old value comes back on the read bus in the same cycle. When a write is requested, the new value from the integer source is stored at the next clock edge.

Completing arithmetic operations report exception flags on a separate input. Those flags are OR-ed into the stored field, and they stay set until software writes the field. Raising a flag never causes a trap.

For each issued operation the block resolves the effective rounding mode. It uses the instruction's static field, or the stored dynamic mode when the instruction asks for it. It also signals an illegal instruction when the dynamic mode it would use holds an undefined encoding.

Top module: `fpu_ctl_word`

## Requirements
- R1: After reset the stored rounding mode is 000 and all five flags are 0. A reset asserted in the middle of operation clears both fields again.
- R2: Whole-word access (select code 00) returns {zeros, rounding mode in bits 7:5, flags in bits 4:0}. An access with the write bit low changes nothing.
- R3: A whole-word swap returns the old word in the same cycle. From the next cycle on, the rounding mode equals source bits 7:5 and the flags equal source bits 4:0.
- R4: Rounding-mode access (select code 01) returns the mode zero-extended into bits 2:0. A swap stores only source bits 2:0 and leaves the flags unchanged.
- R5: Flag access (select code 10) returns the flags zero-extended into bits 4:0. A swap stores only source bits 4:0 and leaves the rounding mode unchanged.
- R6: Read-data bits 31:8 are always zero, and source bits 31:8 never affect stored state.
- R7: A hardware flag report ORs the reported bits into the flags. The flag order from bit 4 down to bit 0 is invalid, divide-by-zero, overflow, underflow, inexact. Flags never clear except by a software write of the flag field.
- R8: When a software write of the flag field (whole-word or flag swap) and a hardware flag report occur in the same cycle, the software value is stored. A rounding-mode-only swap does not block a hardware flag report.
- R9: The effective rounding mode output equals the instruction field for fields 000 through 110. For field 111 it equals the stored dynamic mode as it was before any same-cycle swap. The defined modes are 000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity and 100 nearest-max-magnitude.
- R10: The illegal indication is high exactly when an operation is valid, its field is 111, and the stored dynamic mode is 101, 110 or 111.
- R11: With no access valid, or with select code 11, the read bus is zero and no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | Software access this cycle |
| acc_sel_i | input | 2 | Access target: 00 word, 01 rounding mode, 10 flags, 11 none |
| acc_wr_i | input | 1 | Swap: store the new value after returning the old one |
| acc_wdata_i | input | XLEN | Integer source value |
| acc_rdata_o | output | XLEN | Old value returned to the integer destination |
| exc_valid_i | input | 1 | Hardware flag report from a completing operation |
| exc_flags_i | input | 5 | Reported flags {invalid, div-by-zero, overflow, underflow, inexact} |
| op_valid_i | input | 1 | An operation is being issued |
| op_rm_i | input | 3 | Instruction rounding-mode field (111 = dynamic) |
| op_rm_o | output | 3 | Effective rounding mode for the issued operation |
| op_illegal_o | output | 1 | Dynamic mode requested while the stored mode is undefined |
| cur_rm_o | output | 3 | Stored dynamic rounding mode |
| cur_flags_o | output | 5 | Stored accrued flags |

## Verification
On every cycle the assertions check several properties. Reserved read bits are always zero, and field reads are zero-extended. The flags keep every set bit whenever software does not write them. Each swap lands its source bits in the right field on the next cycle. Static rounding fields pass through unchanged, and the illegal indication matches the dynamic-mode rule.

Some behaviours can only be shown by the bench's scenarios. These are the exact bit placement of a whole-word swap, and the priority of a software flag write over a simultaneous hardware report. They also include the fact that a same-cycle rounding-mode swap does not block a hardware report, and that an operation issued alongside a swap sees the old mode. The bench also shows that a mid-run reset restores the reset state.

// File: rtl/fpcw_pkg.sv
package fpcw_pkg;

    localparam int RM_W   = 3;
    localparam int FLAG_W = 5;
    localparam int WORD_W = RM_W + FLAG_W;

    // access target codes
    localparam logic [1:0] SEL_WORD  = 2'b00;
    localparam logic [1:0] SEL_RM    = 2'b01;
    localparam logic [1:0] SEL_FLAGS = 2'b10;

    // rounding-mode codes
    localparam logic [RM_W-1:0] RM_NEAR_EVEN = 3'b000;
    localparam logic [RM_W-1:0] RM_LAST_OK   = 3'b100;
    localparam logic [RM_W-1:0] RM_DYNAMIC   = 3'b111;

    // flag bit positions, most significant first
    localparam int FLG_INVALID = 4;
    localparam int FLG_DIVZERO = 3;
    localparam int FLG_OVERFL  = 2;
    localparam int FLG_UNDERFL = 1;
    localparam int FLG_INEXACT = 0;

    typedef struct packed {
        logic [RM_W-1:0]   rm;
        logic [FLAG_W-1:0] flags;
    } ctl_word_t;

endpackage

// File: rtl/fpcw_access.sv
module fpcw_access
    import fpcw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              acc_valid_i,
    input  logic [1:0]        acc_sel_i,
    input  logic              acc_wr_i,
    input  logic [WORD_W-1:0] acc_wdata_i,
    input  ctl_word_t         word_q_i,
    output logic [XLEN-1:0]   rdata_o,
    output logic              wr_rm_o,
    output logic [RM_W-1:0]   new_rm_o,
    output logic              wr_flags_o,
    output logic [FLAG_W-1:0] new_flags_o
);

    logic [WORD_W-1:0] field_rd;
    logic              sel_word, sel_rm, sel_flags;

    always_comb begin
        sel_word  = acc_valid_i && (acc_sel_i == SEL_WORD);
        sel_rm    = acc_valid_i && (acc_sel_i == SEL_RM);
        sel_flags = acc_valid_i && (acc_sel_i == SEL_FLAGS);

        field_rd = '0;
        if (sel_word) begin
            field_rd = word_q_i;
        end else if (sel_rm) begin
            field_rd[RM_W-1:0] = word_q_i.rm;
        end else if (sel_flags) begin
            field_rd[FLAG_W-1:0] = word_q_i.flags;
        end

        wr_rm_o     = acc_wr_i && (sel_word || sel_rm);
        wr_flags_o  = acc_wr_i && (sel_word || sel_flags);
        new_rm_o    = sel_word ? acc_wdata_i[WORD_W-1:FLAG_W] : acc_wdata_i[RM_W-1:0];
        new_flags_o = acc_wdata_i[FLAG_W-1:0];
    end

    generate
        if (XLEN > WORD_W) begin : g_pad
            assign rdata_o = {{(XLEN-WORD_W){1'b0}}, field_rd};
        end else begin : g_nopad
            assign rdata_o = field_rd[XLEN-1:0];
        end
    endgenerate

endmodule

// File: rtl/fpcw_rm_resolve.sv
module fpcw_rm_resolve
    import fpcw_pkg::*;
(
    input  logic            op_valid_i,
    input  logic [RM_W-1:0] op_rm_i,
    input  logic [RM_W-1:0] dyn_rm_i,
    output logic [RM_W-1:0] eff_rm_o,
    output logic            illegal_o
);

    logic use_dyn;

    always_comb begin
        use_dyn   = (op_rm_i == RM_DYNAMIC);
        eff_rm_o  = use_dyn ? dyn_rm_i : op_rm_i;
        illegal_o = op_valid_i && use_dyn && (dyn_rm_i > RM_LAST_OK);
    end

endmodule

// File: rtl/fpu_ctl_word.sv
module fpu_ctl_word
    import fpcw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              acc_valid_i,
    input  logic [1:0]        acc_sel_i,
    input  logic              acc_wr_i,
    input  logic [XLEN-1:0]   acc_wdata_i,
    output logic [XLEN-1:0]   acc_rdata_o,
    input  logic              exc_valid_i,
    input  logic [FLAG_W-1:0] exc_flags_i,
    input  logic              op_valid_i,
    input  logic [RM_W-1:0]   op_rm_i,
    output logic [RM_W-1:0]   op_rm_o,
    output logic              op_illegal_o,
    output logic [RM_W-1:0]   cur_rm_o,
    output logic [FLAG_W-1:0] cur_flags_o
);

    ctl_word_t         word_d, word_q;
    logic              wr_rm, wr_flags;
    logic [RM_W-1:0]   new_rm;
    logic [FLAG_W-1:0] new_flags;
    logic              unused_rsvd;

    // reserved source bits never reach the stored state
    assign unused_rsvd = ^acc_wdata_i[XLEN-1:WORD_W];

    fpcw_access #(.XLEN(XLEN)) u_access (
        .acc_valid_i (acc_valid_i),
        .acc_sel_i   (acc_sel_i),
        .acc_wr_i    (acc_wr_i),
        .acc_wdata_i (acc_wdata_i[WORD_W-1:0]),
        .word_q_i    (word_q),
        .rdata_o     (acc_rdata_o),
        .wr_rm_o     (wr_rm),
        .new_rm_o    (new_rm),
        .wr_flags_o  (wr_flags),
        .new_flags_o (new_flags)
    );

    fpcw_rm_resolve u_resolve (
        .op_valid_i (op_valid_i),
        .op_rm_i    (op_rm_i),
        .dyn_rm_i   (word_q.rm),
        .eff_rm_o   (op_rm_o),
        .illegal_o  (op_illegal_o)
    );

    always_comb begin
        word_d = word_q;
        if (wr_rm) begin
            word_d.rm = new_rm;
        end
        if (exc_valid_i) begin
            word_d.flags = word_q.flags | exc_flags_i;
        end
        // a software write of the field wins over a same-cycle report
        if (wr_flags) begin
            word_d.flags = new_flags;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            word_q.rm    <= RM_NEAR_EVEN;
            word_q.flags <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign cur_rm_o    = word_q.rm;
    assign cur_flags_o = word_q.flags;

endmodule

// File: rtl/fpcw_checker.sv
module fpcw_checker #(
    parameter int XLEN = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            acc_valid_i,
    input logic [1:0]      acc_sel_i,
    input logic            acc_wr_i,
    input logic [XLEN-1:0] acc_wdata_i,
    input logic [XLEN-1:0] acc_rdata_o,
    input logic            op_valid_i,
    input logic [2:0]      op_rm_i,
    input logic [2:0]      op_rm_o,
    input logic            op_illegal_o,
    input logic [2:0]      cur_rm_o,
    input logic [4:0]      cur_flags_o
);

    AST_RSVD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_rdata_o[XLEN-1:8] == '0); // R6

    AST_RM_READ_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && acc_sel_i == 2'b01) |-> (acc_rdata_o[XLEN-1:3] == '0)); // R4

    AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!acc_valid_i || acc_sel_i == 2'b11) |-> (acc_rdata_o == '0)); // R11

    AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(acc_valid_i && acc_wr_i && (acc_sel_i == 2'b00 || acc_sel_i == 2'b10))
        |=> ((cur_flags_o & $past(cur_flags_o)) == $past(cur_flags_o))); // R7

    AST_FLAG_SWAP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && acc_wr_i && acc_sel_i == 2'b10)
        |=> (cur_flags_o == $past(acc_wdata_i[4:0]))); // R8

    AST_RM_SWAP_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && acc_wr_i && acc_sel_i == 2'b01)
        |=> (cur_rm_o == $past(acc_wdata_i[2:0]))); // R4

    AST_STATIC_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_rm_i != 3'b111) |-> (op_rm_o == op_rm_i && !op_illegal_o)); // R9

    AST_DYN_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && op_rm_i == 3'b111) |-> (op_illegal_o == (cur_rm_o > 3'b100))); // R10

endmodule

bind fpu_ctl_word fpcw_checker #(.XLEN(XLEN)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .acc_valid_i  (acc_valid_i),
    .acc_sel_i    (acc_sel_i),
    .acc_wr_i     (acc_wr_i),
    .acc_wdata_i  (acc_wdata_i),
    .acc_rdata_o  (acc_rdata_o),
    .op_valid_i   (op_valid_i),
    .op_rm_i      (op_rm_i),
    .op_rm_o      (op_rm_o),
    .op_illegal_o (op_illegal_o),
    .cur_rm_o     (cur_rm_o),
    .cur_flags_o  (cur_flags_o)
);

// File: tb/fpu_ctl_word_tb.sv
`timescale 1ns/1ps
module fpu_ctl_word_tb;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        acc_valid_i = 1'b0;
    logic [1:0]  acc_sel_i = 2'b00;
    logic        acc_wr_i = 1'b0;
    logic [31:0] acc_wdata_i = '0;
    logic [31:0] acc_rdata_o;
    logic        exc_valid_i = 1'b0;
    logic [4:0]  exc_flags_i = '0;
    logic        op_valid_i = 1'b0;
    logic [2:0]  op_rm_i = '0;
    logic [2:0]  op_rm_o;
    logic        op_illegal_o;
    logic [2:0]  cur_rm_o;
    logic [4:0]  cur_flags_o;

    always #2.5 clk_i = ~clk_i;

    fpu_ctl_word #(.XLEN(32)) u_dut (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .acc_valid_i(acc_valid_i), .acc_sel_i(acc_sel_i), .acc_wr_i(acc_wr_i),
        .acc_wdata_i(acc_wdata_i), .acc_rdata_o(acc_rdata_o),
        .exc_valid_i(exc_valid_i), .exc_flags_i(exc_flags_i),
        .op_valid_i(op_valid_i), .op_rm_i(op_rm_i), .op_rm_o(op_rm_o),
        .op_illegal_o(op_illegal_o), .cur_rm_o(cur_rm_o), .cur_flags_o(cur_flags_o)
    );

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    event  sample_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    logic [2:0] rm_m = '0;
    logic [4:0] fl_m = '0;

    // monitor: pops expected items and compares with the outputs
    always begin
        @(sample_ev);
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = acc_rdata_o;
                1: act = {29'b0, op_rm_o};
                2: act = {31'b0, op_illegal_o};
                3: act = {27'b0, cur_flags_o};
                default: act = {29'b0, cur_rm_o};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    function automatic void push(int kind, logic [31:0] exp, string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        q.push_back(it);
    endfunction

    // driver: one cycle of stimulus, expectations from the reference model
    task automatic drive(input logic av, input logic [1:0] sel, input logic wr,
                         input logic [31:0] wd, input logic ev, input logic [4:0] ef,
                         input logic ov, input logic [2:0] orm, input string req);
        logic [31:0] exp_rd;
        @(negedge clk_i);
        acc_valid_i = av; acc_sel_i = sel; acc_wr_i = wr; acc_wdata_i = wd;
        exc_valid_i = ev; exc_flags_i = ef; op_valid_i = ov; op_rm_i = orm;
        #1;
        exp_rd = '0;
        if (av) begin
            case (sel)
                2'b00: exp_rd = {24'b0, rm_m, fl_m};
                2'b01: exp_rd = {29'b0, rm_m};
                2'b10: exp_rd = {27'b0, fl_m};
                default: exp_rd = '0;
            endcase
        end
        push(0, exp_rd, req);
        push(1, {29'b0, (orm == 3'b111) ? rm_m : orm}, req);
        push(2, {31'b0, ov && orm == 3'b111 && rm_m > 3'b100}, req);
        push(3, {27'b0, fl_m}, req);
        push(4, {29'b0, rm_m}, req);
        -> sample_ev;
        if (ev) fl_m = fl_m | ef;
        if (av && wr) begin
            if (sel == 2'b00) begin rm_m = wd[7:5]; fl_m = wd[4:0]; end
            else if (sel == 2'b01) rm_m = wd[2:0];
            else if (sel == 2'b10) fl_m = wd[4:0];
        end
    endtask

    task automatic idle(input string req);
        drive(1'b0, 2'b00, 1'b0, '0, 1'b0, '0, 1'b0, 3'b000, req);
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_ni = 1'b0;
        acc_valid_i = 1'b0; acc_wr_i = 1'b0; exc_valid_i = 1'b0; op_valid_i = 1'b0;
        @(negedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        rm_m = '0; fl_m = '0;
    endtask

    initial begin
        do_reset();
        idle("R1");
        drive(1'b1, 2'b00, 1'b0, '0, 1'b0, '0, 1'b0, 3'b000, "R1");

        // R3/R6: whole-word swap, reserved bits set in the source
        drive(1'b1, 2'b00, 1'b1, 32'hFFFF_FF5A, 1'b0, '0, 1'b0, 3'b000, "R3");
        drive(1'b1, 2'b00, 1'b0, 32'hFFFF_FFFF, 1'b0, '0, 1'b0, 3'b000, "R6");
        drive(1'b1, 2'b00, 1'b0, '0, 1'b0, '0, 1'b0, 3'b000, "R2");

        // R4: rounding-mode field
        drive(1'b1, 2'b01, 1'b0, '0, 1'b0, '0, 1'b0, 3'b000, "R4");
        drive(1'b1, 2'b01, 1'b1, 32'hFFFF_FFFC, 1'b0, '0, 1'b1, 3'b111, "R4");
        drive(1'b1, 2'b01, 1'b0, '0, 1'b0, '0, 1'b1, 3'b111, "R4");

        // R5: flag field
        drive(1'b1, 2'b10, 1'b1, 32'h0000_00E5, 1'b0, '0, 1'b0, 3'b000, "R5");
        drive(1'b1, 2'b00, 1'b0, '0, 1'b0, '0, 1'b0, 3'b000, "R5");

        // R7: sticky hardware reports
        drive(1'b0, 2'b00, 1'b0, '0, 1'b1, 5'b10000, 1'b0, 3'b000, "R7");
        drive(1'b1, 2'b10, 1'b0, '0, 1'b1, 5'b00010, 1'b0, 3'b000, "R7");
        drive(1'b0, 2'b00, 1'b0, '0, 1'b1, 5'b00000, 1'b0, 3'b000, "R7");
        drive(1'b1, 2'b10, 1'b0, '0, 1'b0, '0, 1'b0, 3'b000, "R7");

        // R8: software write priority
        drive(1'b1, 2'b10, 1'b1, 32'h0, 1'b1, 5'b01000, 1'b0, 3'b000, "R8");
        drive(1'b1, 2'b00, 1'b1, 32'h0000_0060, 1'b1, 5'b11111, 1'b0, 3'b000, "R8");
        drive(1'b1, 2'b01, 1'b1, 32'h0000_0001, 1'b1, 5'b00001, 1'b0, 3'b000, "R8");
        idle("R8");

        // R9: static fields pass through, dynamic uses the stored mode
        for (int i = 0; i < 7; i++) begin
            drive(1'b0, 2'b00, 1'b0, '0, 1'b0, '0, 1'b1, 3'(i), "R9");
        end
        drive(1'b0, 2'b00, 1'b0, '0, 1'b0, '0, 1'b1, 3'b111, "R9");

        // R10: undefined dynamic modes; operation alongside a swap sees the old mode
        for (int m = 5; m < 8; m++) begin
            drive(1'b1, 2'b01, 1'b1, 32'(m), 1'b0, '0, 1'b1, 3'b111, "R10");
            drive(1'b0, 2'b00, 1'b0, '0, 1'b0, '0, 1'b1, 3'b111, "R10");
            drive(1'b0, 2'b00, 1'b0, '0, 1'b0, '0, 1'b0, 3'b111, "R10");
            drive(1'b0, 2'b00, 1'b0, '0, 1'b0, '0, 1'b1, 3'b010, "R10");
        end
        drive(1'b1, 2'b01, 1'b1, 32'h4, 1'b0, '0, 1'b1, 3'b111, "R10");
        drive(1'b0, 2'b00, 1'b0, '0, 1'b0, '0, 1'b1, 3'b111, "R10");

        // R11: no access / select code 11
        drive(1'b1, 2'b11, 1'b1, 32'h0000_00FF, 1'b0, '0, 1'b0, 3'b000, "R11");
        drive(1'b0, 2'b00, 1'b1, 32'h0000_00FF, 1'b0, '0, 1'b0, 3'b000, "R11");
        drive(1'b1, 2'b00, 1'b0, '0, 1'b0, '0, 1'b0, 3'b000, "R11");

        // R1: reset mid-run
        drive(1'b1, 2'b00, 1'b1, 32'h0000_00BB, 1'b0, '0, 1'b0, 3'b000, "R1");
        idle("R1");
        do_reset();
        drive(1'b1, 2'b00, 1'b0, '0, 1'b0, '0, 1'b0, 3'b000, "R1");
        idle("R1");

        @(negedge clk_i);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule